// File: doc/BRIEF.md
# Pipeline Data-Hazard Interlock

This block is the stall controller for a five-stage in-order pipeline with no forwarding paths. Every cycle it looks at the instruction in the fetch/decode latch and compares each source register that instruction reads with the destination of each of the two older instructions. Those older instructions sit in the decode/execute and execute/memory latches. The block keeps its own copy of the destination tags of those two latches. It advances the copies in step with the pipeline, so it needs only the fetch/decode fields as input.

When any comparison hits, the block raises `dx_bubble` and drops `pc_we` and `fd_we` in the same cycle. The datapath then loads a nop with cleared control signals into decode/execute and holds the program counter and the fetch/decode latch. The same instruction is presented again on the next cycle, and the test is repeated. The writeback stage is never compared, because the register file resolves a write and a read of the same register in the same cycle. As a result, a dependent instruction that directly follows its producer stalls for two cycles, one that follows one instruction later stalls for one cycle, and one that follows two instructions later does not stall.

The fetch/decode handoff behaves as a valid/ready stream. `fd_valid` marks an instruction as present and `fd_we` acts as the ready. An instruction is consumed on a rising edge where both are high. While `fd_we` is low, the producer must hold every `fd_*` input stable. The block accepts an instruction at most once per cycle and never stalls when `fd_valid` is low.

Top module: `hzd_interlock`

## Requirements
- R1: A hazard is flagged when fetch/decode source 1 or source 2 equals the decode/execute destination.
- R2: A hazard is flagged when fetch/decode source 1 or source 2 equals the execute/memory destination.
- R3: An instruction that has left execute/memory (it is in writeback or later) never causes a hazard.
- R4: An older slot takes part in a comparison only if it is valid, its write flag is 1, and its destination is not register 0.
- R5: A source is compared only when its use flag (`fd_use1` for source 1, `fd_use2` for source 2) is 1. No hazard is flagged while `fd_valid` is 0.
- R6: In a hazard cycle, `dx_bubble` is 1 and both `pc_we` and `fd_we` are 0, all combinationally in that same cycle. Otherwise `dx_bubble` is 0 and both enables are 1.
- R7: After a hazard cycle, the decode/execute slot holds a nop: `dx_valid`=0, `dx_wr`=0, `dx_dst`=0.
- R8: After a non-hazard cycle, decode/execute holds the fetch/decode fields (`dx_valid`=`fd_valid`, plus destination and write flag). Execute/memory takes the decode/execute contents on every edge.
- R9: A dependent instruction directly after its producer stalls exactly 2 cycles. With one instruction between them, it stalls exactly 1 cycle.
- R10: Synchronous reset empties both slots (`dx_valid`=`xm_valid`=0) and deasserts the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fd_valid | input | 1 | Fetch/decode latch holds an instruction |
| fd_src1 | input | REG_AW | Source register 1 field |
| fd_use1 | input | 1 | Instruction reads source 1 |
| fd_src2 | input | REG_AW | Source register 2 field |
| fd_use2 | input | 1 | Instruction reads source 2 |
| fd_dst | input | REG_AW | Destination register field |
| fd_wr | input | 1 | Instruction writes its destination |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode latch write enable (stream ready) |
| dx_bubble | output | 1 | Load nop and clear controls into decode/execute |
| dx_valid | output | 1 | Decode/execute slot valid |
| dx_dst | output | REG_AW | Decode/execute destination |
| dx_wr | output | 1 | Decode/execute write flag |
| xm_valid | output | 1 | Execute/memory slot valid |
| xm_dst | output | REG_AW | Execute/memory destination |
| xm_wr | output | 1 | Execute/memory write flag |

## Verification
The bench measures the stall length of a producer/consumer pair at distances of zero, one and two instructions. A unit that omitted the execute/memory compare would give one stall where two are due, and a unit that also compared writeback would stall where none is due. It checks that register 0, non-writing producers, unused source fields and an invalid fetch/decode slot never cause a stall, since a unit that ignored these qualifiers would stall on independent code. It also confirms that an inserted nop carries no valid or write flag. If the nop kept either flag, the stall would never release, or one bubble would trigger the next.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Number of source operands examined per instruction.
  localparam int unsigned NUM_SRC = 2;
  // Number of older in-flight slots compared (decode/execute, execute/memory).
  localparam int unsigned NUM_OLDER = 2;
  // Index of each older slot inside the comparison arrays.
  localparam int unsigned SLOT_DX = 0;
  localparam int unsigned SLOT_XM = 1;
endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              src_used,
  input  logic              slot_valid,
  input  logic              slot_wr,
  input  logic [REG_AW-1:0] slot_dst,
  output logic              hit
);
  logic live_dst;

  // A slot only produces a value if it is real, writes, and does not target r0.
  always_comb begin
    live_dst = slot_valid && slot_wr && (slot_dst != '0);
    hit      = src_used && live_dst && (src == slot_dst);
  end
endmodule

// File: rtl/hzd_slot.sv
module hzd_slot #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_nop,
  input  logic              in_valid,
  input  logic              in_wr,
  input  logic [REG_AW-1:0] in_dst,
  output logic              q_valid,
  output logic              q_wr,
  output logic [REG_AW-1:0] q_dst
);
  always_ff @(posedge clk) begin
    if (rst || load_nop) begin
      q_valid <= 1'b0;
      q_wr    <= 1'b0;
      q_dst   <= '0;
    end else begin
      q_valid <= in_valid;
      q_wr    <= in_valid && in_wr;
      q_dst   <= in_valid ? in_dst : '0;
    end
  end
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fd_valid,
  input  logic [REG_AW-1:0] fd_src1,
  input  logic              fd_use1,
  input  logic [REG_AW-1:0] fd_src2,
  input  logic              fd_use2,
  input  logic [REG_AW-1:0] fd_dst,
  input  logic              fd_wr,
  output logic              pc_we,
  output logic              fd_we,
  output logic              dx_bubble,
  output logic              dx_valid,
  output logic [REG_AW-1:0] dx_dst,
  output logic              dx_wr,
  output logic              xm_valid,
  output logic [REG_AW-1:0] xm_dst,
  output logic              xm_wr
);
  localparam int unsigned NUM_CMP = NUM_SRC * NUM_OLDER;

  logic [REG_AW-1:0] src_a   [NUM_SRC];
  logic              use_a   [NUM_SRC];
  logic [REG_AW-1:0] old_dst [NUM_OLDER];
  logic              old_val [NUM_OLDER];
  logic              old_wr  [NUM_OLDER];
  logic [NUM_CMP-1:0] hits;
  logic              hazard;

  always_comb begin
    src_a[0] = fd_src1;
    src_a[1] = fd_src2;
    use_a[0] = fd_use1;
    use_a[1] = fd_use2;
    old_dst[SLOT_DX] = dx_dst;
    old_val[SLOT_DX] = dx_valid;
    old_wr[SLOT_DX]  = dx_wr;
    old_dst[SLOT_XM] = xm_dst;
    old_val[SLOT_XM] = xm_valid;
    old_wr[SLOT_XM]  = xm_wr;
  end

  // One comparator per (source field, older slot) pair.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar o = 0; o < NUM_OLDER; o++) begin : g_old
      hzd_match #(.REG_AW(REG_AW)) u_match (
        .src        (src_a[s]),
        .src_used   (use_a[s]),
        .slot_valid (old_val[o]),
        .slot_wr    (old_wr[o]),
        .slot_dst   (old_dst[o]),
        .hit        (hits[s*NUM_OLDER+o])
      );
    end
  end

  always_comb begin
    hazard    = fd_valid && (|hits);
    dx_bubble = hazard;
    pc_we     = !hazard;
    fd_we     = !hazard;
  end

  // Shadow of the decode/execute latch: takes a nop on a hazard.
  hzd_slot #(.REG_AW(REG_AW)) u_dx (
    .clk      (clk),
    .rst      (rst),
    .load_nop (hazard),
    .in_valid (fd_valid),
    .in_wr    (fd_wr),
    .in_dst   (fd_dst),
    .q_valid  (dx_valid),
    .q_wr     (dx_wr),
    .q_dst    (dx_dst)
  );

  // Shadow of the execute/memory latch: always advances.
  hzd_slot #(.REG_AW(REG_AW)) u_xm (
    .clk      (clk),
    .rst      (rst),
    .load_nop (1'b0),
    .in_valid (dx_valid),
    .in_wr    (dx_wr),
    .in_dst   (dx_dst),
    .q_valid  (xm_valid),
    .q_wr     (xm_wr),
    .q_dst    (xm_dst)
  );

  // R7: a bubble cycle leaves an inert nop in decode/execute.
  a_r7_bubble_is_nop: assert property (@(posedge clk) disable iff (rst)
    dx_bubble |=> (!dx_valid && !dx_wr && dx_dst == '0));

  // R8: an accepted instruction appears in decode/execute next cycle.
  a_r8_accept_captured: assert property (@(posedge clk) disable iff (rst)
    (fd_valid && fd_we) |=> (dx_valid && dx_dst == $past(fd_dst) && dx_wr == $past(fd_wr)));

  // R8: execute/memory follows decode/execute by one cycle.
  a_r8_xm_follows_dx: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (xm_valid == $past(dx_valid) && xm_dst == $past(dx_dst) && xm_wr == $past(dx_wr)));

  // R5: no stall without an instruction in fetch/decode.
  a_r5_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
    !fd_valid |-> (pc_we && fd_we && !dx_bubble));

  // R9: with inputs held, a stall never lasts beyond two cycles.
  a_r9_stall_bounded: assert property (@(posedge clk) disable iff (rst)
    (dx_bubble && $past(dx_bubble) && $stable(fd_src1) && $stable(fd_src2)) |=> !dx_bubble
      || !$stable(fd_src1) || !$stable(fd_src2) || !$stable(fd_use1) || !$stable(fd_use2));

  // R10: reset empties both slots.
  a_r10_reset_empties: assert property (@(posedge clk)
    rst |=> (!dx_valid && !xm_valid && !dx_bubble));
endmodule

// File: tb/hzd_interlock_test.sv
`timescale 1ns/1ps
module hzd_interlock_test;
  localparam int unsigned AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fd_valid = 1'b0;
  logic [AW-1:0] fd_src1 = '0, fd_src2 = '0, fd_dst = '0;
  logic fd_use1 = 1'b0, fd_use2 = 1'b0, fd_wr = 1'b0;
  logic pc_we, fd_we, dx_bubble, dx_valid, dx_wr, xm_valid, xm_wr;
  logic [AW-1:0] dx_dst, xm_dst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hzd_interlock #(.REG_AW(AW)) uut (
    .clk(clk), .rst(rst), .fd_valid(fd_valid),
    .fd_src1(fd_src1), .fd_use1(fd_use1), .fd_src2(fd_src2), .fd_use2(fd_use2),
    .fd_dst(fd_dst), .fd_wr(fd_wr),
    .pc_we(pc_we), .fd_we(fd_we), .dx_bubble(dx_bubble),
    .dx_valid(dx_valid), .dx_dst(dx_dst), .dx_wr(dx_wr),
    .xm_valid(xm_valid), .xm_dst(xm_dst), .xm_wr(xm_wr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input bit v, input int s1, input bit u1, input int s2, input bit u2,
                       input int d, input bit w);
    fd_valid = v; fd_src1 = AW'(s1); fd_use1 = u1; fd_src2 = AW'(s2);
    fd_use2 = u2; fd_dst = AW'(d); fd_wr = w;
    #1;
  endtask

  // Independent instruction: reads nothing, writes nothing.
  task automatic filler();
    drive(1, 0, 0, 0, 0, 0, 0);
    tick();
  endtask

  // Present the current instruction until accepted; return stall cycles.
  task automatic accept(output int stalls);
    stalls = 0;
    for (int i = 0; i < 6; i++) begin
      if (fd_we) break;
      stalls++;
      tick();
      #1;
    end
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    tick(); tick();
    rst = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 dx_valid", dx_valid, 0);
    chk("R10 xm_valid", xm_valid, 0);
    chk("R10 pc_we", pc_we, 1);
    chk("R10 dx_bubble", dx_bubble, 0);
  endtask

  task automatic t_back_to_back();
    int st;
    do_reset();
    drive(1, 2, 1, 1, 1, 3, 1);          // writer of r3
    chk("R6 no stall on writer", fd_we, 1);
    tick();
    drive(1, 3, 1, 0, 0, 4, 1);          // reads r3 via source 1
    chk("R1 bubble vs dx", dx_bubble, 1);
    chk("R6 pc_we low", pc_we, 0);
    chk("R6 fd_we low", fd_we, 0);
    tick(); #1;
    chk("R7 dx_valid nop", dx_valid, 0);
    chk("R7 dx_wr nop", dx_wr, 0);
    chk("R8 xm_dst", xm_dst, 3);
    chk("R2 bubble vs xm", dx_bubble, 1);
    tick(); #1;
    chk("R3 released after xm", dx_bubble, 0);
    tick(); #1;
    chk("R8 dx_dst captured", dx_dst, 4);
    chk("R8 dx_valid captured", dx_valid, 1);
    // R9 by count
    do_reset();
    drive(1, 0, 0, 0, 0, 9, 1); tick();
    drive(1, 7, 0, 9, 1, 5, 1);          // reads r9 via source 2
    chk("R1 src2 vs dx", dx_bubble, 1);
    accept(st);
    chk("R9 back-to-back stalls", st, 2);
  endtask

  task automatic t_gaps();
    int st;
    do_reset();
    drive(1, 0, 0, 0, 0, 6, 1); tick();
    filler();
    drive(1, 6, 1, 0, 0, 7, 1);
    chk("R2 one-gap bubble", dx_bubble, 1);
    accept(st);
    chk("R9 one-gap stalls", st, 1);
    do_reset();
    drive(1, 0, 0, 0, 0, 8, 1); tick();
    filler(); filler();
    drive(1, 0, 0, 8, 1, 7, 1);
    chk("R3 writeback not compared", dx_bubble, 0);
    tick();
  endtask

  task automatic t_qualifiers();
    do_reset();
    drive(1, 0, 0, 0, 0, 0, 1); tick();   // writes r0
    drive(1, 0, 1, 0, 1, 2, 1);
    chk("R4 r0 never matches", dx_bubble, 0);
    tick();
    do_reset();
    drive(1, 0, 0, 0, 0, 11, 0); tick();  // dst r11 but no write
    drive(1, 11, 1, 0, 0, 2, 1);
    chk("R4 non-writer ignored", dx_bubble, 0);
    tick();
    do_reset();
    drive(1, 0, 0, 0, 0, 10, 1); tick();
    drive(1, 0, 0, 10, 0, 2, 1);          // src2 matches but unused
    chk("R5 unused source ignored", dx_bubble, 0);
    drive(0, 10, 1, 10, 1, 2, 1);         // invalid slot
    chk("R5 invalid fd no stall", fd_we, 1);
    tick(); #1;
    chk("R8 invalid fd gives empty dx", dx_valid, 0);
  endtask

  task automatic t_mid_reset();
    do_reset();
    drive(1, 0, 0, 0, 0, 12, 1); tick();
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
    tick();
    rst = 1'b0;
    drive(1, 12, 1, 0, 0, 2, 1);
    chk("R10 reset drops producer", dx_bubble, 0);
    tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_back_to_back();
    t_gaps();
    t_qualifiers();
    t_mid_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule